// File: doc/BRIEF.md
# Internal Data Memory Address Mapper

This block sits between the operand decode of an 8-bit core and its on-chip data storage. Each request names an operand in one of six ways: a direct byte address, an indirect pointer value, a banked register number, a bit address, a stack push or a stack pop. One cycle later the block reports which storage space is targeted, the physical byte address inside it and, for bit operands, the bit index.

The upper half of the 8-bit address range is shared. Direct references there reach the special-function-register space. Indirect and stack references there reach an optional second 128-byte RAM. When that RAM is left out by parameter, such references are flagged as having no target. The block also holds the stack pointer and moves it on pushes and pops. Of the status word it uses only the two bank-select bits, which arrive on their own input.

Top module: `idata_addr_map`

## Requirements
- R1: Mode encoding on `req_mode` is 0 direct, 1 indirect, 2 register, 3 bit, 4 push, 5 pop. Codes 6 and 7 give target NONE with address 0. Target encoding on `map_target` is 0 NONE, 1 LOW (lower RAM), 2 HIGH (upper RAM), 3 SFR.
- R2: A direct address 00H–7FH gives LOW at the same address. A direct address 80H–FFH gives SFR at the same address.
- R3: An indirect pointer 00H–7FH gives LOW. A pointer 80H–FFH gives HIGH when `UPPER_EN`=1 and NONE when `UPPER_EN`=0. The address is always the pointer value.
- R4: Register n (from `req_operand[2:0]`) gives LOW at address bank×8+n, where bank is `psw_bank`.
- R5: A bit address below 80H gives LOW, byte 20H+bitaddr[6:3], bit bitaddr[2:0]. A bit address from 80H gives SFR, byte bitaddr with bits 2:0 cleared, bit bitaddr[2:0]. `map_bit_en` is 1 only for bit mode, and `map_bit_idx` is 0 in all other modes.
- R6: The stack pointer is 07H after reset. Outputs show no valid result after reset.
- R7: A push increments the stack pointer (mod 256) and reports the incremented value as the address. The stack is never mapped to SFR.
- R8: A pop reports the current stack pointer as the address and then decrements the pointer (mod 256).
- R9: With `UPPER_EN`=0, a push or pop at 80H–FFH reports NONE, so the write is dropped and the read is undefined. The pointer still moves.
- R10: A result appears on the cycle after its request with `map_valid` high. The stack pointer does not change without a valid push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Operand kind (R1) |
| req_operand | input | 8 | Direct address, register number or bit address |
| req_ptr | input | 8 | Pointer value for indirect mode |
| psw_bank | input | 2 | Register bank select bits from the status word |
| map_valid | output | 1 | Result valid |
| map_target | output | 2 | Target space (R1) |
| map_addr | output | 8 | Physical byte address |
| map_bit_idx | output | 3 | Bit index within the byte |
| map_bit_en | output | 1 | Result is a bit operand |
| stack_ptr | output | 8 | Current stack pointer |

## Verification
The assertions check on every cycle that the pointer moves by exactly one on push and pop and holds otherwise. They also check that a pop reports the old pointer, that indirect and stack results never land in SFR space, that register results stay in the lowest 32 bytes, and that SFR bit results always use a byte address ending in 0H or 8H. Only the bench scenarios show the exact byte and bit values, the bank arithmetic, and the boundary at 7FH/80H for both values of `UPPER_EN`. They also show the wrap of the pointer past FFH.

// File: rtl/idata_addr_map.sv
module idata_addr_map #(
  parameter bit         UPPER_EN  = 1'b1,
  parameter logic [7:0] SP_RESET  = 8'h07,
  parameter logic [7:0] BIT_BASE  = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_mode,
  input  logic [7:0] req_operand,
  input  logic [7:0] req_ptr,
  input  logic [1:0] psw_bank,
  output logic       map_valid,
  output logic [1:0] map_target,
  output logic [7:0] map_addr,
  output logic [2:0] map_bit_idx,
  output logic       map_bit_en,
  output logic [7:0] stack_ptr
);
  localparam logic [2:0] M_DIR = 3'd0, M_IND = 3'd1, M_REG = 3'd2,
                         M_BIT = 3'd3, M_PUSH = 3'd4, M_POP = 3'd5;
  localparam logic [1:0] T_NONE = 2'd0, T_LOW = 2'd1, T_HIGH = 2'd2, T_SFR = 2'd3;

  logic [7:0] sp_q, sp_n, a_n;
  logic [1:0] t_n;
  logic [2:0] b_n;
  logic       be_n;

  function automatic logic [1:0] ind_space(input logic [7:0] a);
    if (!a[7]) return T_LOW;
    return UPPER_EN ? T_HIGH : T_NONE;
  endfunction

  always_comb begin
    t_n  = T_NONE;
    a_n  = 8'h00;
    b_n  = 3'd0;
    be_n = 1'b0;
    sp_n = sp_q;
    case (req_mode)
      M_DIR: begin
        a_n = req_operand;
        t_n = req_operand[7] ? T_SFR : T_LOW;
      end
      M_IND: begin
        a_n = req_ptr;
        t_n = ind_space(req_ptr);
      end
      M_REG: begin
        a_n = {3'b000, psw_bank, req_operand[2:0]};
        t_n = T_LOW;
      end
      M_BIT: begin
        be_n = 1'b1;
        b_n  = req_operand[2:0];
        if (req_operand[7]) begin
          a_n = {req_operand[7:3], 3'b000};
          t_n = T_SFR;
        end else begin
          a_n = BIT_BASE + {4'b0000, req_operand[6:3]};
          t_n = T_LOW;
        end
      end
      M_PUSH: begin
        sp_n = sp_q + 8'd1;
        a_n  = sp_n;
        t_n  = ind_space(sp_n);
      end
      M_POP: begin
        a_n  = sp_q;
        t_n  = ind_space(sp_q);
        sp_n = sp_q - 8'd1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q        <= SP_RESET;
      map_valid   <= 1'b0;
      map_target  <= T_NONE;
      map_addr    <= 8'h00;
      map_bit_idx <= 3'd0;
      map_bit_en  <= 1'b0;
    end else begin
      map_valid <= req_valid;
      if (req_valid) begin
        sp_q        <= sp_n;
        map_target  <= t_n;
        map_addr    <= a_n;
        map_bit_idx <= b_n;
        map_bit_en  <= be_n;
      end
    end
  end

  assign stack_ptr = sp_q;
endmodule

// File: rtl/idata_addr_map_chk.sv
module idata_addr_map_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_mode,
  input logic       map_valid,
  input logic [1:0] map_target,
  input logic [7:0] map_addr,
  input logic       map_bit_en,
  input logic [7:0] stack_ptr
);
  assert_push_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd4) |=> (stack_ptr == $past(stack_ptr) + 8'd1 && map_addr == stack_ptr));

  assert_push_not_sfr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_mode == 3'd4 || req_mode == 3'd5)) |=> map_target != 2'd3);

  assert_pop_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd5) |=> (stack_ptr == $past(stack_ptr) - 8'd1 && map_addr == $past(stack_ptr)));

  assert_ind_not_sfr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd1) |=> map_target != 2'd3);

  assert_reg_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd2) |=> (map_target == 2'd1 && map_addr < 8'h20));

  assert_sfr_bit_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && map_bit_en && map_target == 2'd3) |-> map_addr[2:0] == 3'd0);

  assert_sp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && (req_mode == 3'd4 || req_mode == 3'd5)) |=> $stable(stack_ptr));

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> map_valid);
endmodule

bind idata_addr_map idata_addr_map_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .map_valid(map_valid), .map_target(map_target), .map_addr(map_addr),
  .map_bit_en(map_bit_en), .stack_ptr(stack_ptr)
);

// File: tb/sim_idata_addr_map.sv
module sim_idata_addr_map;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [2:0] req_mode = 3'd0;
  logic [7:0] req_operand = 8'h00, req_ptr = 8'h00;
  logic [1:0] psw_bank = 2'd0;
  logic       v0, be0, v1, be1;
  logic [1:0] t0, t1;
  logic [7:0] a0, a1, sp0, sp1;
  logic [2:0] b0, b1;

  always #10 clk = ~clk;

  idata_addr_map #(.UPPER_EN(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_mode(req_mode), .req_operand(req_operand), .req_ptr(req_ptr), .psw_bank(psw_bank),
    .map_valid(v0), .map_target(t0), .map_addr(a0), .map_bit_idx(b0), .map_bit_en(be0),
    .stack_ptr(sp0));
  idata_addr_map #(.UPPER_EN(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_mode(req_mode), .req_operand(req_operand), .req_ptr(req_ptr), .psw_bank(psw_bank),
    .map_valid(v1), .map_target(t1), .map_addr(a1), .map_bit_idx(b1), .map_bit_en(be1),
    .stack_ptr(sp1));

  typedef struct {
    logic [1:0] tgt_hi, tgt_no;
    logic [7:0] addr, sp;
    logic [2:0] bidx;
    logic       ben;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic [7:0] sp_m = 8'h07;
  bit done = 1'b0;

  function automatic logic [1:0] ispace(input logic [7:0] a);
    return a[7] ? 2'd2 : 2'd1;
  endfunction

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [7:0] op, input logic [7:0] p,
                       input logic [1:0] bk, input string r);
    exp_t e;
    e.bidx = 3'd0; e.ben = 1'b0; e.addr = 8'h00; e.tgt_hi = 2'd0; e.req = r;
    case (m)
      3'd0: begin e.addr = op; e.tgt_hi = op[7] ? 2'd3 : 2'd1; end
      3'd1: begin e.addr = p; e.tgt_hi = ispace(p); end
      3'd2: begin e.addr = 8'(int'(bk) * 8 + int'(op[2:0])); e.tgt_hi = 2'd1; end
      3'd3: begin
        e.ben = 1'b1; e.bidx = op[2:0];
        if (op >= 8'h80) begin e.addr = op & 8'hF8; e.tgt_hi = 2'd3; end
        else begin e.addr = 8'h20 + 8'(op / 8); e.tgt_hi = 2'd1; end
      end
      3'd4: begin sp_m = sp_m + 8'd1; e.addr = sp_m; e.tgt_hi = ispace(sp_m); end
      3'd5: begin e.addr = sp_m; e.tgt_hi = ispace(sp_m); sp_m = sp_m - 8'd1; end
      default: ;
    endcase
    e.sp = sp_m;
    e.tgt_no = (e.tgt_hi == 2'd2) ? 2'd0 : e.tgt_hi;
    q.push_back(e);
    req_valid = 1'b1; req_mode = m; req_operand = op; req_ptr = p; psw_bank = bk;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk); #1;
      if (rst_n && v0) begin
        if (q.size() == 0) chk(1'b0, "R10", "unexpected valid", 1, 0);
        else begin
          e = q.pop_front();
          chk(t0 == e.tgt_hi, e.req, "target(upper)", t0, e.tgt_hi);
          chk(t1 == e.tgt_no, e.req, "target(no upper)", t1, e.tgt_no);
          chk(a0 == e.addr && a1 == e.addr, e.req, "addr", a0, e.addr);
          chk(b0 == e.bidx && be0 == e.ben, e.req, "bit", {be0, b0}, {e.ben, e.bidx});
          chk(sp0 == e.sp && sp1 == e.sp, e.req, "stack ptr", sp0, e.sp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #1;
    chk(sp0 == 8'h07 && sp1 == 8'h07, "R6", "reset sp", sp0, 8'h07);
    chk(!v0 && !v1, "R6", "reset valid", v0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(3'd0, 8'h05, 8'h00, 2'd0, "R2");
    drive(3'd0, 8'h7F, 8'h00, 2'd0, "R2");
    drive(3'd0, 8'h80, 8'h00, 2'd0, "R2");
    drive(3'd0, 8'hE0, 8'h00, 2'd0, "R2");
    drive(3'd1, 8'h00, 8'h05, 2'd0, "R3");
    drive(3'd1, 8'h00, 8'h7F, 2'd0, "R3");
    drive(3'd1, 8'h00, 8'h80, 2'd0, "R3");
    drive(3'd1, 8'h00, 8'hFF, 2'd0, "R3");
    for (int bk = 0; bk < 4; bk++) begin
      drive(3'd2, 8'h00, 8'h00, 2'(bk), "R4");
      drive(3'd2, 8'hF7, 8'h00, 2'(bk), "R4");
    end
    drive(3'd3, 8'h00, 8'h00, 2'd0, "R5");
    drive(3'd3, 8'h7F, 8'h00, 2'd0, "R5");
    drive(3'd3, 8'h2B, 8'h00, 2'd0, "R5");
    drive(3'd3, 8'h83, 8'h00, 2'd0, "R5");
    drive(3'd3, 8'hF7, 8'h00, 2'd0, "R5");
    drive(3'd6, 8'h12, 8'h34, 2'd1, "R1");
    drive(3'd7, 8'h85, 8'h90, 2'd2, "R1");
    drive(3'd4, 8'h00, 8'h00, 2'd0, "R7");
    drive(3'd5, 8'h00, 8'h00, 2'd0, "R8");
    drive(3'd5, 8'h00, 8'h00, 2'd0, "R8");
    drive(3'd4, 8'h00, 8'h00, 2'd0, "R7");
    repeat (4) @(negedge clk);
    #1;
    chk(sp0 == sp_m, "R10", "idle sp hold", sp0, sp_m);
    while (sp_m != 8'h7F) drive(3'd4, 8'h00, 8'h00, 2'd0, "R7");
    drive(3'd4, 8'h00, 8'h00, 2'd0, "R9");
    drive(3'd4, 8'h00, 8'h00, 2'd0, "R9");
    drive(3'd5, 8'h00, 8'h00, 2'd0, "R9");
    drive(3'd5, 8'h00, 8'h00, 2'd0, "R9");
    drive(3'd5, 8'h00, 8'h00, 2'd0, "R8");
    while (sp_m != 8'hFE) drive(3'd4, 8'h00, 8'h00, 2'd0, "R9");
    drive(3'd4, 8'h00, 8'h00, 2'd0, "R7");
    drive(3'd4, 8'h00, 8'h00, 2'd0, "R7");
    drive(3'd5, 8'h00, 8'h00, 2'd0, "R8");
    drive(3'd5, 8'h00, 8'h00, 2'd0, "R8");
    repeat (4) @(negedge clk);
    #2;
    chk(q.size() == 0, "R10", "results outstanding", q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule